// File: doc/BRIEF.md
# Latched Status Register Bank with Shared Interrupt

This block gathers status from a line receiver into a bank of latched registers that a microprocessor polls, and drives one shared active-low interrupt line. Every register bit is either event-class or alarm-class. An event-class bit captures a single-cycle pulse. An alarm-class bit follows a level input. It stays set while the alarm is present, and it also latches when the alarm changes state in either direction.

Reads are selective. The host first writes a mask to a status register address. Each bit written as 1 copies the current latched value into a readable snapshot and clears the latched bit. Each bit written as 0 leaves both the snapshot and the latched bit alone. The host then reads the snapshot. A further address returns live synchronizer levels with no latching and no prior write. Each status register has its own interrupt mask register, and that register resets to all zeros.

The interrupt follows separate pending flags. An event occurrence or an alarm change sets the pending flag of its bit. A selecting write clears that flag, even when an alarm bit itself stays set because the alarm is still present.

Top module: `stat_irq_bank`

## Requirements
- R1: A pulse on an event-class source sets its latched bit at the next clock edge, and the bit stays 1 until a selecting write clears it.
- R2: A write to status address r (0..NREG-1) loads each snapshot bit whose write-data bit is 1 with the latched value held just before that edge. Those latched bits are cleared at the same edge.
- R3: At bit positions written as 0, the write leaves the snapshot bit unchanged and does not clear the latched bit.
- R4: A cleared event bit stays 0 until a new pulse arrives. A pulse in the same cycle as a clearing write of its bit keeps the bit set.
- R5: An alarm-class bit is 1 in every cycle after its alarm input was high. A clearing write while the alarm is high leaves it set.
- R6: Address 2*NREG returns the live synchronizer inputs with no prior write.
- R7: irq_n is 0 whenever any unmasked pending flag is set. It returns to 1 once selecting writes have cleared every unmasked pending flag.
- R8: Every change of an alarm input, rising or falling, sets both the latched bit and the pending flag of that bit.
- R9: Interrupt mask registers sit at addresses NREG+r, reset to 0, and can be read back. A mask bit of 0 keeps its source off irq_n.
- R10: Reads of addresses above 2*NREG return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NREG*W | Event pulses and alarm levels, W bits per register |
| sync_in | input | W | Live synchronizer status levels |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host register address |
| host_wdata | input | W | Host write data: mask for status registers, value for interrupt mask registers |
| host_rdata | output | W | Host read data for host_addr, combinational |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The bench builds the bank with NREG=2, W=4 and ALARM_BITS=4'b1100, so each register has two event bits and two alarm bits. This small shape makes it possible to sweep every event pattern against every one of the 16 write masks on both registers, with the write both one cycle after the pulse and in the same cycle. Alarm rise, persistence and fall are exercised under masked and unmasked interrupts. The synchronizer input is swept through all 16 values.

// File: rtl/stat_pkg.sv
package stat_pkg;

    typedef enum logic [1:0] {
        ACC_STATUS = 2'd0,
        ACC_MASK   = 2'd1,
        ACC_SYNC   = 2'd2,
        ACC_NONE   = 2'd3
    } acc_e;

    function automatic acc_e classify(input int unsigned addr, input int unsigned nreg);
        if (addr < nreg)             return ACC_STATUS;
        else if (addr < 2 * nreg)    return ACC_MASK;
        else if (addr == 2 * nreg)   return ACC_SYNC;
        else                         return ACC_NONE;
    endfunction

    function automatic int unsigned reg_index(input int unsigned addr, input int unsigned nreg);
        if (addr < nreg) return addr;
        else             return addr - nreg;
    endfunction

endpackage

// File: rtl/stat_edge_det.sv
module stat_edge_det #(
    parameter int W = 8,
    parameter logic [W-1:0] ALARM_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] chg
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src & ALARM_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg = (src & ALARM_BITS) ^ st_q.prev;

endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] ALARM_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] clr,
    input  logic         imask_we,
    input  logic [W-1:0] imask_wdata,
    output logic [W-1:0] snap,
    output logic [W-1:0] imask,
    output logic         irq_req
);
    localparam logic [W-1:0] EVT_BITS = ~ALARM_BITS;

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] pend;
        logic [W-1:0] snap;
        logic [W-1:0] imask;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic [W-1:0] evt_hit;
    logic [W-1:0] alm_lvl;
    logic [W-1:0] alm_chg;

    always_comb begin
        evt_hit = src & EVT_BITS;
        alm_lvl = src & ALARM_BITS;
        alm_chg = chg & ALARM_BITS;
        st_d    = st_q;
        // snapshot takes the pre-edge latched value at selected positions
        st_d.snap = (st_q.snap & ~clr) | (st_q.lat & clr);
        // set terms are ORed after the clear, so a set in the same cycle wins
        st_d.lat  = (st_q.lat & ~clr) | evt_hit | alm_lvl | alm_chg;
        st_d.pend = (st_q.pend & ~clr) | evt_hit | alm_chg;
        if (imask_we) st_d.imask = imask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap    = st_q.snap;
    assign imask   = st_q.imask;
    assign irq_req = |(st_q.pend & st_q.imask);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R1
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.lat & $past(src & EVT_BITS)) == $past(src & EVT_BITS)));

    // R2
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.snap & $past(clr)) == ($past(st_q.lat) & $past(clr))));

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.snap & ~$past(clr)) == ($past(st_q.snap) & ~$past(clr))));

    // R4
    evt_stays_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.lat & $past(clr & ~src & EVT_BITS)) == '0));

    // R5
    alarm_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.lat & $past(src & ALARM_BITS)) == $past(src & ALARM_BITS)));

    // R8
    change_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((st_q.pend & $past(chg & ALARM_BITS)) == $past(chg & ALARM_BITS)));

endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank #(
    parameter int NREG = 2,
    parameter int W = 8,
    parameter logic [W-1:0] ALARM_BITS = 8'hF0,
    localparam int AW = $clog2(2 * NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*W-1:0] src_in,
    input  logic [W-1:0]      sync_in,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [W-1:0]      host_wdata,
    output logic [W-1:0]      host_rdata,
    output logic              irq_n
);
    import stat_pkg::*;

    acc_e        kind;
    int unsigned idx;
    logic [W-1:0] snap_v  [NREG];
    logic [W-1:0] imask_v [NREG];
    logic [NREG-1:0] irq_v;

    always_comb begin
        kind = classify(32'(host_addr), NREG);
        idx  = reg_index(32'(host_addr), NREG);
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [W-1:0] chg;
        logic [W-1:0] clr;
        logic         imask_we;

        always_comb begin
            clr      = (host_we && kind == ACC_STATUS && idx == r) ? host_wdata : '0;
            imask_we = host_we && kind == ACC_MASK && idx == r;
        end

        stat_edge_det #(.W(W), .ALARM_BITS(ALARM_BITS)) edge_i (
            .clk (clk),
            .rst_n (rst_n),
            .src (src_in[r*W +: W]),
            .chg (chg)
        );

        stat_latch_reg #(.W(W), .ALARM_BITS(ALARM_BITS)) latch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (src_in[r*W +: W]),
            .chg         (chg),
            .clr         (clr),
            .imask_we    (imask_we),
            .imask_wdata (host_wdata),
            .snap        (snap_v[r]),
            .imask       (imask_v[r]),
            .irq_req     (irq_v[r])
        );
    end

    always_comb begin
        host_rdata = '0;
        unique case (kind)
            ACC_STATUS: for (int r = 0; r < NREG; r++) if (idx == r) host_rdata = snap_v[r];
            ACC_MASK:   for (int r = 0; r < NREG; r++) if (idx == r) host_rdata = imask_v[r];
            ACC_SYNC:   host_rdata = sync_in;
            default:    host_rdata = '0;
        endcase
    end

    assign irq_n = ~|irq_v;

endmodule

// File: tb/stat_irq_bank_tb.sv
module stat_irq_bank_tb_top;
    localparam int NREG = 2;
    localparam int W = 4;
    localparam logic [W-1:0] ALM = 4'b1100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREG*W-1:0] src = '0;
    logic [W-1:0] sync = '0;
    logic we = 1'b0;
    logic [2:0] addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic irq_n;

    logic [NREG*W-1:0] alm_keep = '0;
    int vectors = 0;
    int fails = 0;

    logic [W-1:0] m_lat [NREG];
    logic [W-1:0] m_pend [NREG];
    logic [W-1:0] m_snap [NREG];
    logic [W-1:0] m_prev [NREG];
    logic [W-1:0] m_imask [NREG];

    always #2 clk = ~clk;

    stat_irq_bank #(.NREG(NREG), .W(W), .ALARM_BITS(ALM)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src), .sync_in(sync),
        .host_we(we), .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata), .irq_n(irq_n)
    );

    // behavioural model of the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                m_lat[r] <= '0; m_pend[r] <= '0; m_snap[r] <= '0;
                m_prev[r] <= '0; m_imask[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                logic [W-1:0] s, c, ev, ch;
                s  = src[r*W +: W];
                c  = (we && addr == 3'(r)) ? wdata : '0;
                ev = s & ~ALM;
                ch = (s & ALM) ^ m_prev[r];
                m_snap[r] <= (m_snap[r] & ~c) | (m_lat[r] & c);
                m_lat[r]  <= (m_lat[r] & ~c) | ev | (s & ALM) | ch;
                m_pend[r] <= (m_pend[r] & ~c) | ev | ch;
                m_prev[r] <= s & ALM;
                if (we && addr == 3'(NREG + r)) m_imask[r] <= wdata;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic cyc(input logic [NREG*W-1:0] evts, input logic w,
                       input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        src = evts | alm_keep; we = w; addr = a; wdata = d;
        @(posedge clk);
    endtask

    task automatic chk(input logic [2:0] a, input string req);
        logic [W-1:0] exp;
        logic exp_irq;
        @(negedge clk);
        we = 1'b0; src = alm_keep; addr = a;
        #1;
        if (a < 3'(NREG))          exp = m_snap[a];
        else if (a < 3'(2 * NREG)) exp = m_imask[a - 3'(NREG)];
        else if (a == 3'(2 * NREG)) exp = sync;
        else                       exp = '0;
        exp_irq = ~|((m_pend[0] & m_imask[0]) | (m_pend[1] & m_imask[1]));
        vectors++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d rdata %b expected %b", req, a, rdata, exp);
        end
        vectors++;
        if (irq_n !== exp_irq) begin
            fails++;
            $display("FAIL R7 irq_n %b expected %b (during %s)", irq_n, exp_irq, req);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // reset state: R9 masks zero, R10 unused address
        for (int a = 0; a < 6; a++) chk(3'(a), "R9/R10 reset");

        // event sweep R1 R2 R3 R4
        for (int r = 0; r < NREG; r++) begin
            for (int p = 0; p < 4; p++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [NREG*W-1:0] ev;
                    ev = (NREG*W)'(p) << (r * W);
                    cyc(ev, 1'b0, 3'(r), 4'h0);
                    cyc('0, 1'b1, 3'(r), 4'(m));
                    chk(3'(r), "R2");
                    cyc('0, 1'b1, 3'(r), 4'hF);
                    chk(3'(r), "R3");
                    cyc(ev, 1'b1, 3'(r), 4'(m));
                    chk(3'(r), "R4 coincident");
                    cyc('0, 1'b1, 3'(r), 4'hF);
                    chk(3'(r), "R4");
                    cyc('0, 1'b1, 3'(r), 4'hF);
                    chk(3'(r), "R1");
                end
            end
        end

        // alarms R5 R8 with interrupt enabled on register 0
        cyc('0, 1'b1, 3'd2, 4'hF);
        chk(3'd2, "R9 mask write");
        alm_keep = 8'b0000_0100;
        cyc('0, 1'b0, 3'd0, 4'h0);
        chk(3'd0, "R8 rise");
        cyc('0, 1'b1, 3'd0, 4'h4);
        chk(3'd0, "R5");
        cyc('0, 1'b1, 3'd0, 4'h4);
        chk(3'd0, "R5 persist");
        alm_keep = '0;
        cyc('0, 1'b0, 3'd0, 4'h0);
        chk(3'd0, "R8 fall");
        cyc('0, 1'b1, 3'd0, 4'h4);
        chk(3'd0, "R8 fall read");
        cyc('0, 1'b1, 3'd0, 4'h4);
        chk(3'd0, "R5 released");

        // masked alarm on register 1 keeps irq high: R9
        alm_keep = 8'b1000_0000;
        cyc('0, 1'b0, 3'd0, 4'h0);
        chk(3'd1, "R9 masked alarm");
        cyc('0, 1'b1, 3'd1, 4'h8);
        chk(3'd1, "R5 reg1");

        // event interrupt on register 1, bit 0 enabled only
        cyc('0, 1'b1, 3'd3, 4'h1);
        chk(3'd3, "R9 mask readback");
        cyc(8'b0010_0000, 1'b0, 3'd0, 4'h0);
        chk(3'd1, "R9 masked event");
        cyc(8'b0001_0000, 1'b0, 3'd0, 4'h0);
        chk(3'd1, "R7 event irq");
        cyc('0, 1'b1, 3'd1, 4'h1);
        chk(3'd1, "R7 release");
        alm_keep = '0;
        cyc('0, 1'b1, 3'd1, 4'hF);
        chk(3'd1, "R7 final");

        // live synchronizer sweep R6
        for (int v = 0; v < 16; v++) begin
            sync = 4'(v);
            chk(3'd4, "R6");
        end
        chk(3'd5, "R10");
        chk(3'd7, "R10");

        summary();
    end
endmodule